// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Flagged Receive Queue

This block turns an asynchronous serial line into parallel characters. A one-cycle enable, `tick16_i`, pulses sixteen times per bit period; every decision inside the receiver is taken on such a pulse. The line passes through a synchronizer chain. A falling edge is then confirmed at the middle of the start bit, and each later bit is sampled at its centre.

Assembled characters are written into a receive queue. Each entry holds the data together with its own parity, framing and break flags. Character length (5 to 8 bits) and parity (none, odd or even) come from static configuration inputs. The receiver checks one stop bit, so it accepts frames sent with any stop-bit count. The queue holds sixteen entries when enabled and acts as a single holding slot when disabled. A consumer reads it with a one-cycle pop strobe, and a sticky overrun flag records characters that were lost.

Top module: `serial_rx_engine`

## Requirements
- R1: After reset, `rx_ready_o`, `rx_ovr_o`, `rx_level_o`, `rx_data_o` and the three character flags are all zero.
- R2: A low level is first seen on a tick. If the line is high again on the eighth tick after that, the start is rejected: no character is produced and the receiver goes back to looking for a new falling edge.
- R3: Once a start bit is confirmed, each following bit is sampled every 16 ticks, least significant bit first. `cfg_len_i` selects the length (0 = 5, 1 = 6, 2 = 7, 3 = 8 bits). The data is right-aligned in `rx_data_o` with the unused upper bits zero. The character enters the queue on the tick that samples the stop bit.
- R4: With `cfg_par_en_i` = 1, one parity bit follows the data. `cfg_par_odd_i` = 1 asks for an odd count of ones over data plus parity, and 0 asks for an even count. A mismatch sets `rx_perr_o` for that character only.
- R5: If the first stop bit is sampled low and the frame is not a break, `rx_ferr_o` is set for that character.
- R6: If every sample of a frame is low (start, data, parity and stop), one character is queued with data 0x00, `rx_brk_o` = 1, `rx_ferr_o` = 0 and `rx_perr_o` = 0. No new start is accepted until the line has been sampled high on a tick.
- R7: The queue holds up to DEPTH (16) entries when `fifo_en_i` = 1 and one entry when it is 0. Entries leave in arrival order. `rd_en_i` removes the head when the queue is not empty, and `rx_level_o` gives the entry count.
- R8: A character that completes while the queue is at its limit is discarded and sets `rx_ovr_o`. The flag stays set until a cycle with `ovr_clr_i` = 1. A new overrun in that same cycle keeps it set.
- R9: The data and flags shown belong to the head entry. When the queue is empty they read zero and `rx_ready_o` is 0.
- R10: A change of `fifo_en_i` empties the queue, so `rx_level_o` is zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Sixteen-per-bit sampling enable |
| rx_serial_i | input | 1 | Asynchronous serial line, idle high |
| cfg_len_i | input | 2 | Character length code |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | Odd (1) or even (0) parity |
| fifo_en_i | input | 1 | Sixteen-entry mode (1) or single slot (0) |
| rd_en_i | input | 1 | Pop the head entry |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| rx_ready_o | output | 1 | Queue holds at least one character |
| rx_data_o | output | 8 | Head character data |
| rx_perr_o | output | 1 | Head character parity error |
| rx_ferr_o | output | 1 | Head character framing error |
| rx_brk_o | output | 1 | Head character is a break |
| rx_ovr_o | output | 1 | Sticky overrun |
| rx_level_o | output | 5 | Number of queued characters |

## Verification
The checker relies on `fifo_en_i` being steady across the release of reset. Otherwise the queue-emptying rule has no defined previous mode to compare against. It also takes the configuration inputs as steady for the length of a frame. The stimulus holds the queue mode at one during reset and changes configuration only while the line is idle. It moves the serial line only on the cycle right after a tick, which gives the synchronizer time to settle before the next sample. The bench's behavioural model can therefore read the line directly on each tick.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W  = 8;
    localparam int LEN_W   = 2;
    localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP,
        PH_HOLD
    } rx_phase_e;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_word_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             par_en,
    input  logic             par_odd,
    output logic             push,
    output rx_word_t         word
);

    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_phase_e         phase;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              par;
        logic              zero;
    } smp_state_t;

    smp_state_t s_d, s_q;
    logic [IDX_W-1:0] len_last;
    logic [IDX_W-1:0] shamt;
    logic             is_brk;

    assign len_last = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_len);
    assign shamt    = IDX_W'((1 << LEN_W) - 1) - IDX_W'(cfg_len);
    assign is_brk   = s_q.zero & ~rx;

    always_comb begin
        s_d  = s_q;
        push = 1'b0;
        word = '0;
        if (tick) begin
            case (s_q.phase)
                PH_IDLE: begin
                    if (!rx) begin
                        s_d.phase = PH_START;
                        s_d.cnt   = '0;
                    end
                end
                PH_START: begin
                    if (s_q.cnt == MID_LAST) begin
                        s_d.cnt = '0;
                        if (rx) begin
                            s_d.phase = PH_IDLE;
                        end else begin
                            s_d.phase = PH_DATA;
                            s_d.idx   = '0;
                            s_d.shreg = '0;
                            s_d.par   = 1'b0;
                            s_d.zero  = 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (s_q.cnt == BIT_LAST) begin
                        s_d.cnt   = '0;
                        s_d.shreg = {rx, s_q.shreg[DATA_W-1:1]};
                        s_d.par   = s_q.par ^ rx;
                        s_d.zero  = s_q.zero & ~rx;
                        if (s_q.idx == len_last) begin
                            s_d.phase = par_en ? PH_PARITY : PH_STOP;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_PARITY: begin
                    if (s_q.cnt == BIT_LAST) begin
                        s_d.cnt   = '0;
                        s_d.par   = s_q.par ^ rx;
                        s_d.zero  = s_q.zero & ~rx;
                        s_d.phase = PH_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_STOP: begin
                    if (s_q.cnt == BIT_LAST) begin
                        s_d.cnt   = '0;
                        push      = 1'b1;
                        word.brk  = is_brk;
                        word.ferr = ~rx & ~is_brk;
                        word.perr = par_en & ~is_brk & (par_odd ? ~s_q.par : s_q.par);
                        word.data = is_brk ? '0 : (s_q.shreg >> shamt);
                        s_d.phase = is_brk ? PH_HOLD : PH_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (rx) s_d.phase = PH_IDLE;
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  rx_word_t                   wdata,
    input  logic                       pop,
    input  logic [$clog2(DEPTH+1)-1:0] limit,
    output rx_word_t                   head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       overflow
);

    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [LVL_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t f_d, f_q;
    rx_word_t    mem_q [DEPTH];
    logic        push_ok, pop_ok, at_limit;

    assign at_limit = (f_q.cnt >= limit);
    assign push_ok  = push & ~at_limit & ~flush;
    assign pop_ok   = pop & (f_q.cnt != '0) & ~flush;
    assign overflow = push & at_limit & ~flush;

    always_comb begin
        f_d = f_q;
        if (flush) begin
            f_d = '0;
        end else begin
            if (push_ok) f_d.wp = (f_q.wp == PTR_LAST) ? '0 : f_q.wp + 1'b1;
            if (pop_ok)  f_d.rp = (f_q.rp == PTR_LAST) ? '0 : f_q.rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   f_d.cnt = f_q.cnt + 1'b1;
                2'b01:   f_d.cnt = f_q.cnt - 1'b1;
                default: f_d.cnt = f_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[f_q.wp] <= wdata;
    end

    assign head  = (f_q.cnt == '0) ? '0 : mem_q[f_q.rp];
    assign level = f_q.cnt;

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
    import srx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick16_i,
    input  logic                       rx_serial_i,
    input  logic [1:0]                 cfg_len_i,
    input  logic                       cfg_par_en_i,
    input  logic                       cfg_par_odd_i,
    input  logic                       fifo_en_i,
    input  logic                       rd_en_i,
    input  logic                       ovr_clr_i,
    output logic                       rx_ready_o,
    output logic [7:0]                 rx_data_o,
    output logic                       rx_perr_o,
    output logic                       rx_ferr_o,
    output logic                       rx_brk_o,
    output logic                       rx_ovr_o,
    output logic [$clog2(DEPTH+1)-1:0] rx_level_o
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic ovr;
        logic mode;
    } top_state_t;

    top_state_t t_d, t_q;
    logic       rx_sync;
    logic       push;
    rx_word_t   word, head;
    logic       flush, overflow;
    logic [LVL_W-1:0] limit, level;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_serial_i),
        .dout  (rx_sync)
    );

    srx_sampler #(.OSR(OSR)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16_i),
        .rx      (rx_sync),
        .cfg_len (cfg_len_i),
        .par_en  (cfg_par_en_i),
        .par_odd (cfg_par_odd_i),
        .push    (push),
        .word    (word)
    );

    assign flush = (fifo_en_i != t_q.mode);
    assign limit = fifo_en_i ? LVL_W'(DEPTH) : LVL_W'(1);

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (push),
        .wdata    (word),
        .pop      (rd_en_i),
        .limit    (limit),
        .head     (head),
        .level    (level),
        .overflow (overflow)
    );

    always_comb begin
        t_d      = t_q;
        t_d.mode = fifo_en_i;
        t_d.ovr  = ovr_clr_i ? overflow : (t_q.ovr | overflow);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.ovr  <= 1'b0;
            t_q.mode <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end

    assign rx_ready_o = (level != '0);
    assign rx_data_o  = head.data;
    assign rx_perr_o  = head.perr;
    assign rx_ferr_o  = head.ferr;
    assign rx_brk_o   = head.brk;
    assign rx_ovr_o   = t_q.ovr;
    assign rx_level_o = level;

endmodule

// File: rtl/serial_rx_engine_chk.sv
module serial_rx_engine_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             ovr_clr,
    input logic             ready,
    input logic [7:0]       data,
    input logic             perr,
    input logic             ferr,
    input logic             brk,
    input logic             ovr,
    input logic [LVL_W-1:0] level
);

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    assert_level_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (level > $past(level)) |-> (level == LVL_W'($past(level) + 1'b1)));

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    assert_mode_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != $past(fifo_en)) |=> (level == '0));

    assert_brk_data_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && brk) |-> (data == 8'h00 && !perr && !ferr));

    assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (data == 8'h00 && !brk && !perr && !ferr));

endmodule

bind serial_rx_engine serial_rx_engine_chk #(
    .DEPTH (DEPTH),
    .LVL_W ($clog2(DEPTH+1))
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en_i),
    .ovr_clr (ovr_clr_i),
    .ready   (rx_ready_o),
    .data    (rx_data_o),
    .perr    (rx_perr_o),
    .ferr    (rx_ferr_o),
    .brk     (rx_brk_o),
    .ovr     (rx_ovr_o),
    .level   (rx_level_o)
);

// File: tb/serial_rx_engine_tb_top.sv
`timescale 1ns/1ps
module serial_rx_engine_tb_top;

    localparam int DEPTH = 16;
    localparam int LVL_W = 5;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic par_en = 1'b0;
    logic par_odd = 1'b0;
    logic fifo_en = 1'b1;
    logic rd_en = 1'b0;
    logic ovr_clr = 1'b0;

    logic             rx_ready, rx_perr, rx_ferr, rx_brk, rx_ovr;
    logic [7:0]       rx_data;
    logic [LVL_W-1:0] rx_level;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int tcnt = 0;

    always #2.5 clk = ~clk;

    serial_rx_engine dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick16_i      (tick16),
        .rx_serial_i   (rx_in),
        .cfg_len_i     (cfg_len),
        .cfg_par_en_i  (par_en),
        .cfg_par_odd_i (par_odd),
        .fifo_en_i     (fifo_en),
        .rd_en_i       (rd_en),
        .ovr_clr_i     (ovr_clr),
        .rx_ready_o    (rx_ready),
        .rx_data_o     (rx_data),
        .rx_perr_o     (rx_perr),
        .rx_ferr_o     (rx_ferr),
        .rx_brk_o      (rx_brk),
        .rx_ovr_o      (rx_ovr),
        .rx_level_o    (rx_level)
    );

    // behavioural model: tick-level decoder plus queue
    int         m_st = 0;
    int         m_cnt = 0;
    logic       m_smp[$];
    logic [10:0] m_q[$];
    logic       m_ovr = 1'b0;
    logic       m_prev_en = 1'b1;

    always @(posedge clk) begin
        logic        m_push;
        logic [10:0] m_word;
        logic        ovf;
        int          nb, total, ones;
        logic        allz;
        logic [7:0]  d;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_smp.delete(); m_q.delete();
            m_ovr = 1'b0; m_prev_en = 1'b1;
        end else begin
            m_push = 1'b0;
            m_word = '0;
            ovf = 1'b0;
            nb = int'(cfg_len) + 5;
            total = nb + (par_en ? 1 : 0) + 1;
            if (tick16) begin
                if (m_st == 0) begin
                    if (!rx_in) begin m_st = 1; m_cnt = 0; end
                end else if (m_st == 1) begin
                    m_cnt++;
                    if (m_cnt == 8) begin
                        m_cnt = 0;
                        if (rx_in) m_st = 0;
                        else begin m_st = 2; m_smp.delete(); end
                    end
                end else if (m_st == 2) begin
                    m_cnt++;
                    if (m_cnt == 16) begin
                        m_cnt = 0;
                        m_smp.push_back(rx_in);
                        if (m_smp.size() == total) begin
                            allz = 1'b1;
                            foreach (m_smp[i]) if (m_smp[i]) allz = 1'b0;
                            m_push = 1'b1;
                            if (allz) begin
                                m_word = {1'b1, 1'b0, 1'b0, 8'h00};
                                m_st = 3;
                            end else begin
                                d = '0; ones = 0;
                                for (int i = 0; i < nb; i++) begin
                                    d[i] = m_smp[i];
                                    if (m_smp[i]) ones++;
                                end
                                if (par_en && m_smp[nb]) ones++;
                                m_word[7:0] = d;
                                m_word[8] = par_en && (par_odd ? (ones % 2 == 0) : (ones % 2 == 1));
                                m_word[9] = !m_smp[total-1];
                                m_st = 0;
                            end
                        end
                    end
                end else begin
                    if (rx_in) m_st = 0;
                end
            end
            if (fifo_en != m_prev_en) begin
                m_q.delete();
            end else begin
                int lim;
                logic full;
                lim = fifo_en ? DEPTH : 1;
                full = (m_q.size() >= lim);
                if (rd_en && m_q.size() > 0) void'(m_q.pop_front());
                if (m_push) begin
                    if (full) ovf = 1'b1;
                    else m_q.push_back(m_word);
                end
            end
            m_ovr = ovr_clr ? ovf : (m_ovr | ovf);
            m_prev_en = fifo_en;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // tick generator, per-cycle comparison, watchdog
    always @(negedge clk) begin
        logic [10:0] hd;
        cyc++;
        tcnt = (tcnt + 1) % 4;
        tick16 = (tcnt == 3);
        if (rst_n) begin
            hd = (m_q.size() > 0) ? m_q[0] : 11'h0;
            check("R7 level", 32'(rx_level), 32'(m_q.size()));
            check("R9 ready", 32'(rx_ready), 32'(m_q.size() > 0));
            check("R3 data", 32'(rx_data), 32'(hd[7:0]));
            check("R4 perr", 32'(rx_perr), 32'(hd[8]));
            check("R5 ferr", 32'(rx_ferr), 32'(hd[9]));
            check("R6 brk", 32'(rx_brk), 32'(hd[10]));
            check("R8 ovr", 32'(rx_ovr), 32'(m_ovr));
        end
        if (cyc > WATCHDOG) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic wait_tick();
        @(posedge clk);
        while (!tick16) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hold(input logic lvl, input int n);
        rx_in = lvl;
        repeat (n) wait_tick();
    endtask

    task automatic send_char(input logic [7:0] d, input logic flip_par, input logic stop_lvl);
        int nb;
        logic p;
        nb = int'(cfg_len) + 5;
        wait_tick();
        hold(1'b0, 16);
        p = 1'b0;
        for (int i = 0; i < nb; i++) begin
            hold(d[i], 16);
            p = p ^ d[i];
        end
        if (par_en) hold((par_odd ? ~p : p) ^ flip_par, 16);
        hold(stop_lvl, 16);
        hold(1'b1, 20);
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic clear_ovr();
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 32'(rx_ready), 0);
        check("R1 level", 32'(rx_level), 0);
        check("R1 ovr", 32'(rx_ovr), 0);
        check("R1 data", 32'({rx_brk, rx_ferr, rx_perr, rx_data}), 0);

        // R3 eight data bits, no parity
        send_char(8'hA5, 1'b0, 1'b1);
        check("R3 8-bit data", 32'(rx_data), 32'h A5);
        check("R3 8-bit flags", 32'({rx_brk, rx_ferr, rx_perr}), 0);
        pop();
        check("R7 empty after pop", 32'(rx_level), 0);

        // R3 shorter lengths, upper bits zero
        cfg_len = 2'd0; send_char(8'hF3, 1'b0, 1'b1);
        check("R3 5-bit data", 32'(rx_data), 32'h13);
        pop();
        cfg_len = 2'd1; send_char(8'hEC, 1'b0, 1'b1);
        check("R3 6-bit data", 32'(rx_data), 32'h2C);
        pop();
        cfg_len = 2'd2; send_char(8'hDA, 1'b0, 1'b1);
        check("R3 7-bit data", 32'(rx_data), 32'h5A);
        pop();

        // R4 parity
        cfg_len = 2'd3; par_en = 1'b1; par_odd = 1'b0;
        send_char(8'h3C, 1'b0, 1'b1);
        check("R4 even good", 32'(rx_perr), 0);
        pop();
        send_char(8'h3D, 1'b1, 1'b1);
        check("R4 even bad", 32'(rx_perr), 1);
        check("R4 even bad data", 32'(rx_data), 32'h3D);
        pop();
        par_odd = 1'b1;
        send_char(8'h07, 1'b0, 1'b1);
        check("R4 odd good", 32'(rx_perr), 0);
        pop();
        send_char(8'h07, 1'b1, 1'b1);
        check("R4 odd bad", 32'(rx_perr), 1);
        pop();
        par_en = 1'b0; par_odd = 1'b0;

        // R5 framing error, R9 flags follow their own character
        send_char(8'h11, 1'b0, 1'b1);
        send_char(8'h81, 1'b0, 1'b0);
        check("R9 head first", 32'(rx_data), 32'h11);
        check("R9 head first ferr", 32'(rx_ferr), 0);
        pop();
        check("R5 ferr set", 32'(rx_ferr), 1);
        check("R5 ferr data", 32'(rx_data), 32'h81);
        pop();
        check("R9 empty quiet", 32'({rx_ready, rx_brk, rx_ferr, rx_perr, rx_data}), 0);

        // R2 false start
        wait_tick();
        hold(1'b0, 5);
        hold(1'b1, 30);
        check("R2 glitch rejected", 32'(rx_level), 0);
        send_char(8'h5C, 1'b0, 1'b1);
        check("R2 recovery data", 32'(rx_data), 32'h5C);
        pop();

        // R6 break
        wait_tick();
        hold(1'b0, 16 * 10 + 40);
        check("R6 single break entry", 32'(rx_level), 1);
        hold(1'b1, 20);
        check("R6 break data", 32'(rx_data), 0);
        check("R6 break flag", 32'(rx_brk), 1);
        check("R6 break no ferr", 32'(rx_ferr), 0);
        check("R6 one entry", 32'(rx_level), 1);
        pop();

        // R8 overrun in sixteen-entry mode, R7 order
        for (int i = 0; i < DEPTH + 1; i++) send_char(8'h40 + 8'(i), 1'b0, 1'b1);
        check("R7 full level", 32'(rx_level), DEPTH);
        check("R8 overrun set", 32'(rx_ovr), 1);
        for (int i = 0; i < DEPTH; i++) begin
            check("R7 order", 32'(rx_data), 32'(8'h40 + 8'(i)));
            pop();
        end
        check("R8 overrun sticky", 32'(rx_ovr), 1);
        clear_ovr();
        check("R8 overrun cleared", 32'(rx_ovr), 0);

        // R10 mode change flush, R7 single slot
        send_char(8'h21, 1'b0, 1'b1);
        send_char(8'h22, 1'b0, 1'b1);
        check("R7 two queued", 32'(rx_level), 2);
        @(negedge clk); fifo_en = 1'b0;
        @(negedge clk);
        check("R10 flushed", 32'(rx_level), 0);
        send_char(8'h31, 1'b0, 1'b1);
        send_char(8'h32, 1'b0, 1'b1);
        check("R7 single slot level", 32'(rx_level), 1);
        check("R7 single slot keeps first", 32'(rx_data), 32'h31);
        check("R8 single slot overrun", 32'(rx_ovr), 1);
        pop();
        clear_ovr();
        @(negedge clk); fifo_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 back to queue mode", 32'(rx_level), 0);

        finish_run();
    end

endmodule